// File: doc/BRIEF.md
# Dual-Mode Quad-Channel Host Bus Front End

This block sits between a host processor bus and four UART channel cores. A strap input picks one of two bus styles. In strobe-pair style, the host has separate active-low read and write strobes and one active-low chip select per channel. In combined style, one active-low chip select enables the whole device, two address lines pick the channel, and a single read/write line carries the access: its falling edge writes and its rising edge reads. Two of the select pins change role between the styles. In combined style they carry the channel address bits.

All bus pins are synchronized to the system clock. Each access becomes exactly one registered write or read pulse, issued together with a channel select vector, a 3-bit register address and the captured write data. Read data from the channel cores is multiplexed onto a three-state data bus, which is modelled as a value and an enable. The block also adapts the reset pin polarity to the selected style.

Interrupt routing follows the style. In strobe-pair style, each channel has its own three-state active-high interrupt output. In combined style, the channels share one open-drain active-low request.

Top module: `qhif_top`

## Requirements
- R1: `bus_sel_i`=1 selects strobe-pair style and `bus_sel_i`=0 selects combined style. In both styles `reg_addr_o` carries `addr_i[2:0]` captured with the access.
- R2: In strobe-pair style, `sel_n_i[i]` low selects channel i. A falling edge of `wr_n_i` while at least one select is low gives one `wr_pulse_o`. With that pulse, `chan_sel_o` has bit i set for every low select, and `wr_data_o` equals `dat_i`.
- R3: In combined style, `sel_n_i[0]` is the device select. The channel number is {`sel_n_i[2]`,`sel_n_i[1]`}, with `sel_n_i[1]` as the LSB. During an access `chan_sel_o` is one-hot with that bit set, and `sel_n_i[3]` is ignored.
- R4: Each qualified strobe edge gives exactly one pulse, one clock wide, on the third rising clock edge after the edge reaches the pins.
- R5: In combined style, a falling edge of `wr_n_i` (used as read/write line) with the device selected gives a write pulse. A rising edge gives a read pulse. `rd_n_i` has no effect.
- R6: In strobe-pair style, a falling edge of `rd_n_i` with a select low gives one `rd_pulse_o`. `dat_oe_o` is high while `rd_n_i` is low and a select is low. `dat_o` carries the read data of the lowest-numbered selected channel.
- R7: In combined style, `dat_oe_o` is high while the read/write line is high and the device is selected.
- R8: In strobe-pair style, `int_o[i]` equals `irq_pend_i[i]`. `int_oe_o[i]` is `out_en_i[i]` OR `irq_force_i`. `irq_oe_o` is 0.
- R9: In combined style, `int_oe_o` is all zero and `irq_n_o` is 0. `irq_oe_o` is high while any `irq_pend_i` bit is high. `irq_force_i` has no effect.
- R10: Reset is `rst_pin_i`=1 in strobe-pair style and `rst_pin_i`=0 in combined style. `rst_o` rises at once and falls two clocks after release. While `rst_o` is high, all pulses and all output enables are 0.
- R11: Strobe edges with no select low give no pulse and no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| bus_sel_i | input | 1 | Style strap: 1 strobe-pair, 0 combined |
| rst_pin_i | input | 1 | Reset pin, polarity set by style |
| sel_n_i | input | 4 | Select pins (per-channel selects, or device select plus channel address) |
| addr_i | input | 3 | Register address |
| rd_n_i | input | 1 | Read strobe (strobe-pair style only) |
| wr_n_i | input | 1 | Write strobe, or read/write line in combined style |
| dat_i | input | 8 | Data bus, input side |
| dat_o | output | 8 | Data bus, output value |
| dat_oe_o | output | 1 | Data bus drive enable |
| rd_data_i | input | 32 | Read data of the four channels, channel 0 in the low byte |
| chan_sel_o | output | 4 | Channel select vector |
| reg_addr_o | output | 3 | Register address to the channels |
| wr_data_o | output | 8 | Write data to the channels |
| wr_pulse_o | output | 1 | One-clock write pulse |
| rd_pulse_o | output | 1 | One-clock read pulse |
| irq_pend_i | input | 4 | Interrupt pending per channel |
| out_en_i | input | 4 | Per-channel interrupt output enable (modem control bit 3) |
| irq_force_i | input | 1 | Forces all interrupt outputs enabled (strobe-pair style) |
| int_o | output | 4 | Per-channel interrupt value |
| int_oe_o | output | 4 | Per-channel interrupt drive enable |
| irq_n_o | output | 1 | Shared request value (active low) |
| irq_oe_o | output | 1 | Shared request pull-down enable |
| rst_o | output | 1 | Synchronized active-high reset to the cores |

## Verification
On every cycle, the assertions check the following:
- Read and write pulses never coincide.
- Each pulse is one clock wide.
- A pulse always carries a non-empty channel select, which is one-hot in combined style.
- Each style leaves the other style's interrupt enables off.
- Forcing enables every interrupt output.
- Reset keeps the bus and the interrupts quiet.

Only the bench scenarios can show the following:
- The three-clock latency.
- The lowest-channel read priority.
- The mapping of select pins to channel numbers in each style.
- The captured address and data values.
- That the read strobe and the force input are ignored in combined style.

// File: rtl/qhif_pkg.sv
package qhif_pkg;
  localparam int NCH = 4;

  // strobe-pair style selects: pin low -> channel selected
  function automatic logic [NCH-1:0] sel_pair(input logic [NCH-1:0] pins);
    return ~pins;
  endfunction

  // combined style: pin0 is device select, pins 2:1 give the channel number
  function automatic logic [NCH-1:0] sel_comb(input logic [NCH-1:0] pins);
    logic [NCH-1:0] v;
    v = '0;
    if (!pins[0]) v[{pins[2], pins[1]}] = 1'b1;
    return v;
  endfunction

  // index of lowest set bit (0 when none)
  function automatic logic [1:0] low_index(input logic [NCH-1:0] v);
    logic [1:0] idx;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) if (v[i]) idx = 2'(i);
    return idx;
  endfunction
endpackage

// File: rtl/qhif_rst_sync.sv
module qhif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic bus_sel_i,
  input  logic rst_pin_i,
  output logic rst_o
);
  logic          raw_rst;
  logic [STAGES-1:0] chain;

  assign raw_rst = bus_sel_i ? rst_pin_i : ~rst_pin_i;

  always_ff @(posedge clk or posedge raw_rst) begin
    if (raw_rst) chain <= '1;
    else         chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/qhif_in_sync.sv
module qhif_in_sync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qhif_decode.sv
module qhif_decode
  import qhif_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pair_mode,
  input  logic [NCH-1:0] sel_s,
  input  logic           rd_s,
  input  logic           wr_s,
  input  logic [AW-1:0]  addr_s,
  input  logic [DW-1:0]  dat_s,
  output logic [NCH-1:0] chan_sel_o,
  output logic [AW-1:0]  reg_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           wr_pulse_o,
  output logic           rd_pulse_o,
  output logic           drive_o
);
  logic           rd_prev, wr_prev;
  logic [NCH-1:0] chan_cmb;
  logic           cs_any;
  logic           wr_edge, rd_edge, rd_level;

  always_comb begin
    chan_cmb = pair_mode ? sel_pair(sel_s) : sel_comb(sel_s);
    cs_any   = |chan_cmb;
    wr_edge  = wr_prev & ~wr_s;
    rd_edge  = pair_mode ? (rd_prev & ~rd_s) : (~wr_prev & wr_s);
    rd_level = pair_mode ? ~rd_s : wr_s;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rd_prev    <= 1'b1;
      wr_prev    <= 1'b1;
      chan_sel_o <= '0;
      reg_addr_o <= '0;
      wr_data_o  <= '0;
      wr_pulse_o <= 1'b0;
      rd_pulse_o <= 1'b0;
      drive_o    <= 1'b0;
    end else begin
      rd_prev    <= rd_s;
      wr_prev    <= wr_s;
      chan_sel_o <= chan_cmb;
      reg_addr_o <= addr_s;
      wr_data_o  <= dat_s;
      wr_pulse_o <= wr_edge & cs_any;
      rd_pulse_o <= rd_edge & cs_any;
      drive_o    <= rd_level & cs_any;
    end
  end
endmodule

// File: rtl/qhif_irq_route.sv
module qhif_irq_route
  import qhif_pkg::*;
(
  input  logic           rst,
  input  logic           pair_mode,
  input  logic [NCH-1:0] irq_pend_i,
  input  logic [NCH-1:0] out_en_i,
  input  logic           irq_force_i,
  output logic [NCH-1:0] int_o,
  output logic [NCH-1:0] int_oe_o,
  output logic           irq_n_o,
  output logic           irq_oe_o
);
  always_comb begin
    int_o    = '0;
    int_oe_o = '0;
    irq_n_o  = 1'b0;
    irq_oe_o = 1'b0;
    if (!rst) begin
      if (pair_mode) begin
        int_o    = irq_pend_i;
        int_oe_o = out_en_i | {NCH{irq_force_i}};
      end else begin
        irq_oe_o = |irq_pend_i;
      end
    end
  end
endmodule

// File: rtl/qhif_top.sv
module qhif_top
  import qhif_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              bus_sel_i,
  input  logic              rst_pin_i,
  input  logic [NCH-1:0]    sel_n_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [DW-1:0]     dat_i,
  output logic [DW-1:0]     dat_o,
  output logic              dat_oe_o,
  input  logic [NCH*DW-1:0] rd_data_i,
  output logic [NCH-1:0]    chan_sel_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              wr_pulse_o,
  output logic              rd_pulse_o,
  input  logic [NCH-1:0]    irq_pend_i,
  input  logic [NCH-1:0]    out_en_i,
  input  logic              irq_force_i,
  output logic [NCH-1:0]    int_o,
  output logic [NCH-1:0]    int_oe_o,
  output logic              irq_n_o,
  output logic              irq_oe_o,
  output logic              rst_o
);
  localparam int IW = NCH + 2 + AW + DW;

  logic [IW-1:0]  pins_raw, pins_s;
  logic [NCH-1:0] sel_s;
  logic           rd_s, wr_s;
  logic [AW-1:0]  addr_s;
  logic [DW-1:0]  dat_s;
  logic           drive;
  logic [1:0]     rd_idx;

  qhif_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .bus_sel_i(bus_sel_i), .rst_pin_i(rst_pin_i), .rst_o(rst_o)
  );

  assign pins_raw = {sel_n_i, rd_n_i, wr_n_i, addr_i, dat_i};

  qhif_in_sync #(.W(IW), .STAGES(SYNC_STAGES),
                 .IDLE({{(NCH+2){1'b1}}, {(AW+DW){1'b0}}})) u_sync (
    .clk(clk), .rst(rst_o), .d(pins_raw), .q(pins_s)
  );

  assign {sel_s, rd_s, wr_s, addr_s, dat_s} = pins_s;

  qhif_decode #(.DW(DW), .AW(AW)) u_dec (
    .clk(clk), .rst(rst_o), .pair_mode(bus_sel_i),
    .sel_s(sel_s), .rd_s(rd_s), .wr_s(wr_s), .addr_s(addr_s), .dat_s(dat_s),
    .chan_sel_o(chan_sel_o), .reg_addr_o(reg_addr_o), .wr_data_o(wr_data_o),
    .wr_pulse_o(wr_pulse_o), .rd_pulse_o(rd_pulse_o), .drive_o(drive)
  );

  // read priority: lowest-numbered selected channel
  assign rd_idx   = low_index(chan_sel_o);
  assign dat_o    = rd_data_i[rd_idx*DW +: DW];
  assign dat_oe_o = drive & ~rst_o;

  qhif_irq_route u_irq (
    .rst(rst_o), .pair_mode(bus_sel_i), .irq_pend_i(irq_pend_i),
    .out_en_i(out_en_i), .irq_force_i(irq_force_i), .int_o(int_o),
    .int_oe_o(int_oe_o), .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
  );
endmodule

// File: rtl/qhif_checker.sv
module qhif_checker (
  input logic       clk,
  input logic       rst_o,
  input logic       bus_sel_i,
  input logic       irq_force_i,
  input logic       wr_pulse_o,
  input logic       rd_pulse_o,
  input logic       dat_oe_o,
  input logic [3:0] chan_sel_o,
  input logic [3:0] int_oe_o,
  input logic       irq_oe_o
);
  a_r4_no_double_access: assert property (@(posedge clk) disable iff (rst_o)
    !(wr_pulse_o && rd_pulse_o));
  a_r4_wr_one_clock: assert property (@(posedge clk) disable iff (rst_o)
    wr_pulse_o |=> !wr_pulse_o);
  a_r4_rd_one_clock: assert property (@(posedge clk) disable iff (rst_o)
    rd_pulse_o |=> !rd_pulse_o);
  a_r11_pulse_has_channel: assert property (@(posedge clk) disable iff (rst_o)
    (wr_pulse_o || rd_pulse_o) |-> (chan_sel_o != 4'b0));
  a_r3_comb_onehot: assert property (@(posedge clk) disable iff (rst_o)
    (!bus_sel_i && (wr_pulse_o || rd_pulse_o)) |-> ($countones(chan_sel_o) == 1));
  a_r9_comb_no_int_oe: assert property (@(posedge clk) disable iff (rst_o)
    !bus_sel_i |-> (int_oe_o == 4'b0));
  a_r8_pair_no_shared_req: assert property (@(posedge clk) disable iff (rst_o)
    bus_sel_i |-> !irq_oe_o);
  a_r8_force_enables: assert property (@(posedge clk) disable iff (rst_o)
    (bus_sel_i && irq_force_i) |-> (int_oe_o == 4'b1111));
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst_o |-> (!dat_oe_o && !wr_pulse_o && !rd_pulse_o && int_oe_o == 4'b0 && !irq_oe_o));
endmodule

bind qhif_top qhif_checker u_chk (
  .clk(clk), .rst_o(rst_o), .bus_sel_i(bus_sel_i), .irq_force_i(irq_force_i),
  .wr_pulse_o(wr_pulse_o), .rd_pulse_o(rd_pulse_o), .dat_oe_o(dat_oe_o),
  .chan_sel_o(chan_sel_o), .int_oe_o(int_oe_o), .irq_oe_o(irq_oe_o)
);

// File: tb/qhif_top_bench.sv
`timescale 1ns/1ps
module qhif_top_bench;
  logic        clk = 1'b0;
  logic        bus_sel_i = 1'b1;
  logic        rst_pin_i = 1'b1;
  logic [3:0]  sel_n_i = 4'hF;
  logic [2:0]  addr_i = '0;
  logic        rd_n_i = 1'b1, wr_n_i = 1'b1;
  logic [7:0]  dat_i = '0;
  logic [7:0]  dat_o;
  logic        dat_oe_o;
  logic [31:0] rd_data_i = 32'h44332211;
  logic [3:0]  chan_sel_o;
  logic [2:0]  reg_addr_o;
  logic [7:0]  wr_data_o;
  logic        wr_pulse_o, rd_pulse_o;
  logic [3:0]  irq_pend_i = '0, out_en_i = '0;
  logic        irq_force_i = 1'b0;
  logic [3:0]  int_o, int_oe_o;
  logic        irq_n_o, irq_oe_o, rst_o;

  int total = 0, bad = 0;
  int wr_cnt, rd_cnt, first_idx, oe_cnt;
  logic [3:0] cap_chan;
  logic [2:0] cap_addr;
  logic [7:0] cap_wdat, cap_rdat;

  always #2.5 clk = ~clk;

  qhif_top u_qhif_top (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_watch();
    wr_cnt = 0; rd_cnt = 0; oe_cnt = 0; first_idx = -1;
    cap_chan = '0; cap_addr = '0; cap_wdat = '0; cap_rdat = '0;
  endtask

  // observes n falling clock edges, after a drive made on a falling edge
  task automatic watch(input int n);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wr_pulse_o || rd_pulse_o) begin
        if (first_idx < 0) first_idx = i;
        cap_chan = chan_sel_o; cap_addr = reg_addr_o; cap_wdat = wr_data_o;
      end
      if (wr_pulse_o) wr_cnt++;
      if (rd_pulse_o) rd_cnt++;
      if (dat_oe_o) begin oe_cnt++; cap_rdat = dat_o; end
    end
  endtask

  task automatic t_reset_pair();
    @(negedge clk); rst_pin_i = 1'b1; irq_force_i = 1'b1; irq_pend_i = 4'hF;
    #1;
    chk(rst_o === 1'b1, "R10 rst_o high on pin=1 pair style", rst_o, 1);
    chk(int_oe_o === 4'h0, "R10 int_oe in reset", int_oe_o, 0);
    @(negedge clk); rst_pin_i = 1'b0;
    @(posedge clk); #1;
    chk(rst_o === 1'b1, "R10 rst_o held one clock", rst_o, 1);
    @(posedge clk); #1;
    chk(rst_o === 1'b0, "R10 rst_o released after two clocks", rst_o, 0);
    chk(wr_pulse_o === 1'b0 && rd_pulse_o === 1'b0 && dat_oe_o === 1'b0,
        "R10 idle after reset", {wr_pulse_o, rd_pulse_o, dat_oe_o}, 0);
    irq_force_i = 1'b0; irq_pend_i = 4'h0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_pair_write();
    clear_watch();
    @(negedge clk); sel_n_i = 4'b1101; addr_i = 3'd5; dat_i = 8'hA5;
    @(negedge clk); wr_n_i = 1'b0;
    watch(6);
    chk(wr_cnt == 1, "R2 one write pulse", wr_cnt, 1);
    chk(first_idx == 3, "R4 write latency", first_idx, 3);
    chk(cap_chan == 4'b0010, "R2 channel B selected", cap_chan, 4'b0010);
    chk(cap_addr == 3'd5, "R1 register address", cap_addr, 5);
    chk(cap_wdat == 8'hA5, "R2 write data", cap_wdat, 8'hA5);
    chk(rd_cnt == 0 && oe_cnt == 0, "R2 no read on write", rd_cnt, 0);
    clear_watch();
    @(negedge clk); wr_n_i = 1'b1; sel_n_i = 4'hF;
    watch(5);
    chk(wr_cnt == 0 && rd_cnt == 0, "R4 no pulse on strobe release", wr_cnt, 0);
    // two selects at once
    clear_watch();
    @(negedge clk); sel_n_i = 4'b1010; addr_i = 3'd2; dat_i = 8'h3C;
    @(negedge clk); wr_n_i = 1'b0;
    watch(6);
    chk(wr_cnt == 1 && cap_chan == 4'b0101, "R2 write to every selected channel",
        cap_chan, 4'b0101);
    @(negedge clk); wr_n_i = 1'b1; sel_n_i = 4'hF;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_pair_read();
    clear_watch();
    @(negedge clk); sel_n_i = 4'b1001; addr_i = 3'd7;
    @(negedge clk); rd_n_i = 1'b0;
    watch(6);
    chk(rd_cnt == 1 && wr_cnt == 0, "R6 one read pulse", rd_cnt, 1);
    chk(first_idx == 3, "R4 read latency", first_idx, 3);
    chk(oe_cnt >= 3, "R6 bus driven during read", oe_cnt, 3);
    chk(cap_rdat == 8'h22, "R6 lowest selected channel data", cap_rdat, 8'h22);
    @(negedge clk); rd_n_i = 1'b1; sel_n_i = 4'hF;
    repeat (4) @(negedge clk);
    chk(dat_oe_o === 1'b0, "R6 bus released after read", dat_oe_o, 0);
  endtask

  task automatic t_no_select();
    clear_watch();
    @(negedge clk); sel_n_i = 4'hF;
    @(negedge clk); rd_n_i = 1'b0; wr_n_i = 1'b0;
    watch(6);
    @(negedge clk); rd_n_i = 1'b1; wr_n_i = 1'b1;
    watch(5);
    chk(wr_cnt == 0 && rd_cnt == 0 && oe_cnt == 0, "R11 strobes without select ignored",
        {wr_cnt[7:0], rd_cnt[7:0], oe_cnt[7:0]}, 0);
  endtask

  task automatic t_irq_pair();
    @(negedge clk); irq_pend_i = 4'b0101; out_en_i = 4'b0011; irq_force_i = 1'b0;
    #1;
    chk(int_o == 4'b0101, "R8 int value", int_o, 4'b0101);
    chk(int_oe_o == 4'b0011, "R8 int enable from out_en", int_oe_o, 4'b0011);
    chk(irq_oe_o == 1'b0, "R8 shared request off", irq_oe_o, 0);
    irq_force_i = 1'b1; #1;
    chk(int_oe_o == 4'b1111, "R8 force enables all", int_oe_o, 4'b1111);
    irq_force_i = 1'b0; irq_pend_i = '0; out_en_i = '0;
  endtask

  task automatic to_combined();
    @(negedge clk); rst_pin_i = 1'b1;
    @(negedge clk); bus_sel_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(rst_o === 1'b0, "R10 combined style out of reset with pin=1", rst_o, 0);
  endtask

  task automatic t_comb_write();
    clear_watch();
    @(negedge clk); addr_i = 3'd3; dat_i = 8'h5A; sel_n_i = 4'b1100; // channel 2
    @(negedge clk); wr_n_i = 1'b0;
    @(negedge clk); rd_n_i = 1'b0;
    watch(6);
    @(negedge clk); rd_n_i = 1'b1;
    @(negedge clk); sel_n_i = 4'hF;
    @(negedge clk); wr_n_i = 1'b1;
    watch(5);
    chk(wr_cnt == 1, "R5 combined write pulse", wr_cnt, 1);
    chk(cap_chan == 4'b0100, "R3 channel 2 one-hot", cap_chan, 4'b0100);
    chk(cap_addr == 3'd3 && cap_wdat == 8'h5A, "R1 combined addr and data",
        {cap_addr, cap_wdat}, {3'd3, 8'h5A});
    chk(rd_cnt == 0, "R5 read strobe ignored, no read", rd_cnt, 0);
  endtask

  task automatic t_comb_read();
    clear_watch();
    @(negedge clk); wr_n_i = 1'b0;
    @(negedge clk); sel_n_i = 4'b0110; // channel 3, unused pin3 low
    watch(5);
    chk(wr_cnt == 0 && oe_cnt == 0, "R7 no drive while line low", oe_cnt, 0);
    clear_watch();
    @(negedge clk); wr_n_i = 1'b1;
    watch(6);
    chk(rd_cnt == 1 && wr_cnt == 0, "R5 rising line gives read", rd_cnt, 1);
    chk(first_idx == 3, "R4 combined read latency", first_idx, 3);
    chk(cap_chan == 4'b1000, "R3 channel 3 selected", cap_chan, 4'b1000);
    chk(oe_cnt >= 3 && cap_rdat == 8'h44, "R7 combined read data on bus", cap_rdat, 8'h44);
    @(negedge clk); sel_n_i = 4'hF;
    repeat (4) @(negedge clk);
    chk(dat_oe_o === 1'b0, "R7 bus released on deselect", dat_oe_o, 0);
  endtask

  task automatic t_irq_comb();
    @(negedge clk); irq_pend_i = 4'b0100; out_en_i = 4'hF; irq_force_i = 1'b1;
    #1;
    chk(irq_oe_o == 1'b1 && irq_n_o == 1'b0, "R9 shared request asserted",
        {irq_oe_o, irq_n_o}, 2'b10);
    chk(int_oe_o == 4'b0, "R9 per-channel enables off, force ignored", int_oe_o, 0);
    irq_pend_i = 4'b0; #1;
    chk(irq_oe_o == 1'b0, "R9 request released", irq_oe_o, 0);
    irq_force_i = 1'b0; out_en_i = 4'h0;
  endtask

  task automatic t_reset_comb();
    @(negedge clk); irq_pend_i = 4'hF; rst_pin_i = 1'b0;
    #1;
    chk(rst_o === 1'b1, "R10 combined reset on pin=0", rst_o, 1);
    chk(irq_oe_o === 1'b0, "R10 request off in reset", irq_oe_o, 0);
    @(negedge clk); rst_pin_i = 1'b1; irq_pend_i = 4'h0;
    repeat (3) @(negedge clk);
    chk(rst_o === 1'b0, "R10 combined reset released", rst_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pair();
    t_pair_write();
    t_pair_read();
    t_no_select();
    t_irq_pair();
    to_combined();
    t_comb_write();
    t_comb_read();
    t_irq_comb();
    t_reset_comb();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule